// File: doc/BRIEF.md
# Byte-Serial Status Packet Generator

This block reports a small status payload to a downstream collector over an 8-bit byte-serial path. A packet is a fixed header byte carrying the status register address, followed by data bytes that hold a 6-bit sequence tag and the payload bits. The request line is high for every byte except the last. The header byte is held on the bus until the collector acknowledges it with a start pulse. After that the remaining bytes go out one per cycle, and the request drops on the final byte.

A one-byte control register sets when reports are due and which sequence tag they carry. The command decoder writes it with a write-enable pulse. Bits 1:0 select the mode, and bits 7:2 hold the sequence tag. The payload width and the header address are parameters. The default is a 2-bit payload with header 0x04, which gives a two-byte packet.

Top module: `status_stream_tx`

## Requirements
- R1: Asynchronous reset (rst_ni low) forces rq_o to 0 and ad_o to 0x00 at once, and clears the control register to mode 0, so no packet follows the release of reset until a new write.
- R2: When a packet launches, rq_o rises in the cycle after the launch decision with ad_o = STATUS_ADDR. Both hold unchanged for as long as start_i is low.
- R3: The cycle after start_i is sampled high, ad_o carries the data byte {seq[5:0], payload[1:0]} (seq in bits 7:2, payload in bits 1:0) with rq_o low. The following cycle ad_o returns to 0x00 with rq_o low.
- R4: In mode 0 (control bits 1:0 = 00) no packet is launched, whatever the payload does.
- R5: In mode 1 (bits 1:0 = 01), each control write queues exactly one packet. The packet launches on the clock edge after the one that applied the write. No second packet follows without a new write.
- R6: In mode 2 (bits 1:0 = 10), a packet launches only when the payload differs from the payload carried by the previous packet. That reference value is 0 after reset.
- R7: In mode 3 (bits 1:0 = 11), packets repeat. After the final byte there is exactly one idle cycle (rq_o low, ad_o 0x00) before the next header.
- R8: A control write that arrives while a packet is in flight does not alter that packet. It takes effect after the packet completes, and no packet under the old setting starts in between. A write in an idle cycle takes effect at that edge, while a packet launched at the same edge still uses the old tag.
- R9: The payload is captured when the packet launches. Payload changes while the packet is in flight do not change its data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wd_i | input | 8 | Control data: bits 7:2 sequence tag, bits 1:0 mode |
| pay_i | input | PAY_W | Status payload bits to report |
| start_i | input | 1 | Downstream acknowledge of the header byte |
| ad_o | output | 8 | Byte-serial address/data output |
| rq_o | output | 1 | Request; high on all packet bytes but the last |

## Verification
A control write can land in the same idle cycle in which a continuous-mode packet launches. The bench provokes this by writing a new tag with send-once mode during the single idle gap between two continuous packets. The launched packet must carry the old tag, and exactly one further packet must follow with the new tag, then silence. A second overlap is a write during the header wait. It is judged by the data byte keeping the old tag and by the absence of any packet after completion.

// File: rtl/stsp_pkg.sv
package stsp_pkg;
  localparam int SEQ_W = 6;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_ONCE   = 2'd1,
    MODE_CHANGE = 2'd2,
    MODE_CONT   = 2'd3
  } rep_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_BODY = 2'd2
  } ser_st_e;
endpackage

// File: rtl/stsp_ctrl.sv
module stsp_ctrl
  import stsp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       wd_i,
  input  logic             busy_i,
  input  logic             launch_i,
  output rep_mode_e        mode_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic             once_o,
  output logic             hold_o
);
  logic       sh_v_q;
  logic [7:0] sh_d_q;
  logic [7:0] apply_d;
  logic       apply_en;

  assign apply_en = !busy_i && (we_i || sh_v_q);
  assign apply_d  = we_i ? wd_i : sh_d_q;
  assign hold_o   = sh_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_OFF;
      seq_o  <= '0;
      once_o <= 1'b0;
      sh_v_q <= 1'b0;
      sh_d_q <= '0;
    end else if (we_i && busy_i) begin
      // packet in flight: park the write
      sh_v_q <= 1'b1;
      sh_d_q <= wd_i;
    end else if (apply_en) begin
      mode_o <= rep_mode_e'(apply_d[1:0]);
      seq_o  <= apply_d[7:2];
      once_o <= (apply_d[1:0] == MODE_ONCE);
      sh_v_q <= 1'b0;
    end else if (launch_i) begin
      once_o <= 1'b0;
    end
  end

  AST_DEFER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && we_i) |=> ($stable(mode_o) && $stable(seq_o))); // R8
endmodule

// File: rtl/stsp_trig.sv
module stsp_trig
  import stsp_pkg::*;
#(
  parameter int PAY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rep_mode_e        mode_i,
  input  logic             once_i,
  input  logic             hold_i,
  input  logic             idle_i,
  input  logic [PAY_W-1:0] pay_i,
  output logic             launch_o
);
  logic [PAY_W-1:0] last_q;
  logic             due;

  always_comb begin
    unique case (mode_i)
      MODE_ONCE:   due = once_i;
      MODE_CHANGE: due = (pay_i != last_q);
      MODE_CONT:   due = 1'b1;
      default:     due = 1'b0;
    endcase
  end

  assign launch_o = idle_i && !hold_i && due;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= '0;
    else if (launch_o) last_q <= pay_i;
  end
endmodule

// File: rtl/stsp_ser.sv
module stsp_ser
  import stsp_pkg::*;
#(
  parameter int         PAY_W       = 2,
  parameter logic [7:0] STATUS_ADDR = 8'h04
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [PAY_W-1:0] pay_i,
  input  logic             start_i,
  output logic [7:0]       ad_o,
  output logic             rq_o,
  output logic             idle_o
);
  localparam int WORD_W = SEQ_W + PAY_W;
  localparam int NBYTES = (WORD_W + 7) / 8;
  localparam int IDX_W  = $clog2(NBYTES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);
  localparam logic             MULTI    = (NBYTES > 1);

  ser_st_e               st_q;
  logic [NBYTES*8-1:0]   word_q;
  logic [NBYTES*8-1:0]   word_d;
  logic [IDX_W-1:0]      idx_q;

  assign word_d = (NBYTES*8)'({seq_i, pay_i});
  assign idle_o = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      word_q <= '0;
      idx_q  <= '0;
      ad_o   <= '0;
      rq_o   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (launch_i) begin
          st_q   <= ST_HEAD;
          word_q <= word_d;
          idx_q  <= '0;
          ad_o   <= STATUS_ADDR;
          rq_o   <= 1'b1;
        end
        ST_HEAD: if (start_i) begin
          st_q  <= ST_BODY;
          ad_o  <= word_q[7:0];
          rq_o  <= MULTI;
          idx_q <= IDX_W'(1);
        end
        ST_BODY: begin
          if (!rq_o) begin
            // final byte has been on the bus
            st_q <= ST_IDLE;
            ad_o <= '0;
          end else begin
            ad_o  <= word_q[8*idx_q +: 8];
            rq_o  <= (idx_q != LAST_IDX);
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_HEAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HEAD && !start_i) |=> (rq_o && ad_o == STATUS_ADDR)); // R2
  AST_HEAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rq_o) |-> (ad_o == STATUS_ADDR)); // R2
  AST_TAIL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BODY && !rq_o) |=> (!rq_o && ad_o == 8'h00)); // R3
endmodule

// File: rtl/status_stream_tx.sv
module status_stream_tx
  import stsp_pkg::*;
#(
  parameter int         PAY_W       = 2,
  parameter logic [7:0] STATUS_ADDR = 8'h04
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [7:0]       ctrl_wd_i,
  input  logic [PAY_W-1:0] pay_i,
  input  logic             start_i,
  output logic [7:0]       ad_o,
  output logic             rq_o
);
  rep_mode_e        mode;
  logic [SEQ_W-1:0] seq;
  logic             once, hold, idle, launch;

  stsp_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wd_i    (ctrl_wd_i),
    .busy_i  (!idle),
    .launch_i(launch),
    .mode_o  (mode),
    .seq_o   (seq),
    .once_o  (once),
    .hold_o  (hold)
  );

  stsp_trig #(.PAY_W(PAY_W)) u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .once_i  (once),
    .hold_i  (hold),
    .idle_i  (idle),
    .pay_i   (pay_i),
    .launch_o(launch)
  );

  stsp_ser #(.PAY_W(PAY_W), .STATUS_ADDR(STATUS_ADDR)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .seq_i   (seq),
    .pay_i   (pay_i),
    .start_i (start_i),
    .ad_o    (ad_o),
    .rq_o    (rq_o),
    .idle_o  (idle)
  );

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_OFF && idle) |=> !rq_o); // R4
  AST_ONCE_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && mode == MODE_ONCE && !ctrl_we_i) |=> !once); // R5
endmodule

// File: tb/status_stream_tx_tb.sv
`timescale 1ns/1ps
module status_stream_tx_tb;
  localparam logic [7:0] HDR = 8'h04;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wd = '0;
  logic [1:0] pay = '0;
  logic       start = 1'b0;
  logic [7:0] ad;
  logic       rq;
  int n_cmp = 0;
  int n_bad = 0;

  // {ctrl write, payload, expected data byte}
  localparam logic [17:0] VEC [4] = '{
    {8'hA9, 2'b10, 8'hAA},
    {8'h01, 2'b11, 8'h03},
    {8'hFD, 2'b01, 8'hFD},
    {8'h55, 2'b00, 8'h54}
  };

  always #10 clk = ~clk;

  status_stream_tx #(.PAY_W(2), .STATUS_ADDR(HDR)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we), .ctrl_wd_i(ctrl_wd),
    .pay_i(pay), .start_i(start), .ad_o(ad), .rq_o(rq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    ctrl_we = 1'b1;
    ctrl_wd = d;
    tick();
    ctrl_we = 1'b0;
  endtask

  task automatic quiet(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      tick();
      chk(tag, {31'd0, rq}, 32'd0);
    end
  endtask

  // header is on the bus when called; ends in the idle cycle after the final byte
  task automatic xfer(input string tag, input logic [7:0] exp);
    chk({tag, " R2 header"}, {rq, ad}, {1'b1, HDR});
    tick();
    chk({tag, " R2 hold"}, {rq, ad}, {1'b1, HDR});
    start = 1'b1;
    tick();
    start = 1'b0;
    chk({tag, " R3 data"}, {rq, ad}, {1'b0, exp});
    tick();
    chk({tag, " R3 idle"}, {rq, ad}, 9'd0);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick();
    tick();
    chk("R1 reset bus", {rq, ad}, 9'd0);
    rst_ni = 1'b1;
    quiet("R4 mode0 quiet", 5);
    pay = 2'b11;
    quiet("R4 mode0 payload change", 3);

    for (int i = 0; i < 4; i++) begin
      pay = VEC[i][9:8];
      wr(VEC[i][17:10]);
      tick();
      chk("R5 once launch", {31'd0, rq}, 32'd1);
      xfer("R5 vec", VEC[i][7:0]);
      quiet("R5 single packet", 6);
    end

    wr(8'h16);
    quiet("R6 no change", 5);
    pay = 2'b10;
    tick();
    chk("R6 change launch", {31'd0, rq}, 32'd1);
    xfer("R6", 8'h16);
    quiet("R6 stable payload", 5);
    pay = 2'b01;
    tick();
    chk("R6 second change", {rq, ad}, {1'b1, HDR});
    pay = 2'b11;
    tick();
    start = 1'b1;
    tick();
    start = 1'b0;
    chk("R9 captured payload", {rq, ad}, {1'b0, 8'h15});
    tick();
    tick();
    chk("R6 change after packet", {31'd0, rq}, 32'd1);
    xfer("R6 follow", 8'h17);
    quiet("R6 settled", 3);

    wr(8'h27);
    tick();
    chk("R7 cont launch", {31'd0, rq}, 32'd1);
    xfer("R7", 8'h27);
    tick();
    chk("R7 one idle gap", {rq, ad}, {1'b1, HDR});
    ctrl_we = 1'b1;
    ctrl_wd = 8'h44;
    tick();
    ctrl_we = 1'b0;
    chk("R8 header held", {rq, ad}, {1'b1, HDR});
    start = 1'b1;
    tick();
    start = 1'b0;
    chk("R8 data unaffected", {rq, ad}, {1'b0, 8'h27});
    tick();
    quiet("R8 deferred mode0", 6);

    wr(8'h27);
    tick();
    chk("R7 restart", {31'd0, rq}, 32'd1);
    xfer("R7 again", 8'h27);
    ctrl_we = 1'b1;
    ctrl_wd = 8'h89;
    tick();
    ctrl_we = 1'b0;
    chk("R8 collision launch", {31'd0, rq}, 32'd1);
    xfer("R8 old tag", 8'h27);
    tick();
    chk("R5 queued by collision write", {31'd0, rq}, 32'd1);
    xfer("R5 new tag", 8'h8B);
    quiet("R5 after collision", 6);

    wr(8'h27);
    tick();
    chk("R1 pre-reset packet", {31'd0, rq}, 32'd1);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset", {rq, ad}, 9'd0);
    tick();
    rst_ni = 1'b1;
    quiet("R1 control cleared", 5);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule